// File: doc/BRIEF.md
# Extend-Charge Spread-Spectrum Timer

This block sets the length of the extend-charge interval in a charge-transfer touch-sensing sequencer. A small prescaler divides the system clock into slow extend-charge ticks. The length of one tick is set by a 3-bit divider field. For each charge phase, the block waits a number of these ticks. That number goes up by one tick on each phase, from zero to one more than a 7-bit deviation setting, and then returns to zero. Because every phase has a different length, the emitted energy is spread over a range of frequencies.

The sequencer gives a one-cycle `start` pulse. The block raises `busy` for the interval and then gives a one-cycle `done` pulse. Both fields are captured at `start`. Clearing `en` stops the block at once and returns the sawtooth to its first step.

Top module: `ecs_timer`

## Requirements
- R1: After reset, `busy` and `done` are low and the first accepted interval has a stretch of 0 ticks.
- R2: A `start` sampled high while `en` is high and `busy` is low is accepted. `busy` is high from the next cycle.
- R3: An accepted interval with stretch S and divider D keeps `busy` high for exactly S*(D+1)+1 cycles.
- R4: `done` is high for exactly one cycle, the cycle right after `busy` falls, and `done` and `busy` are never high together.
- R5: Successive stretches follow 0, 1, …, V+1, 0, 1, … for deviation V. With V=0x7F the longest stretch is 128 ticks.
- R6: A `start` pulse that arrives while `busy` is high is ignored. It does not change the interval length and does not advance the sawtooth.
- R7: The divider and deviation fields are captured at acceptance. Changes to them during an interval have no effect on that interval.
- R8: While `en` is low, `busy` and `done` are low and `start` is ignored. Clearing `en` aborts a running interval without a `done` pulse and resets the sawtooth to stretch 0.
- R9: If the deviation is lowered so that the stored step is above the new V+1, the next stretch is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low clears the state |
| div_sel | input | 3 | Tick period minus one, in system clocks |
| dev_sel | input | 7 | Deviation; the top stretch is dev_sel+1 ticks |
| start | input | 1 | Start request from the sequencer |
| busy | output | 1 | Interval running |
| done | output | 1 | One-cycle end-of-interval pulse |

## Verification
The hardest situation to reach from the ports is the top of the sawtooth at large settings, followed by the wrap back to zero. That step occurs only after V+2 complete intervals. The stimulus reaches it in two ways. Random runs use small deviations so that wraps happen often. One directed run uses deviation 0x7F and divider 7, and walks through 130 intervals. Further directed cases cover these situations:
- a deviation lowered below the stored step;
- fields changed and `start` pulsed during a running interval;
- `en` dropped in the middle of an interval.

// File: rtl/ecs_timer.sv
module ecs_timer #(
  parameter int DIV_W = 3,
  parameter int DEV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [DEV_W-1:0] dev_sel,
  input  logic             start,
  output logic             busy,
  output logic             done
);
  localparam int CW = DEV_W + 1;

  logic [DIV_W-1:0] div_q;
  logic [DEV_W-1:0] dev_q;
  logic [DIV_W-1:0] pre;
  logic [CW-1:0]    rem;
  logic [CW-1:0]    step;
  logic [CW-1:0]    top_in;
  logic [CW-1:0]    stretch;
  logic             accept;
  logic             tick;

  assign top_in  = CW'(dev_sel) + CW'(1);
  assign stretch = (step > top_in) ? '0 : step;
  assign accept  = en && start && !busy;
  assign tick    = (pre == div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      div_q <= '0;
      dev_q <= '0;
      pre   <= '0;
      rem   <= '0;
      step  <= '0;
    end else if (!en) begin
      busy <= 1'b0;
      done <= 1'b0;
      pre  <= '0;
      rem  <= '0;
      step <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        div_q <= div_sel;
        dev_q <= dev_sel;
        pre   <= '0;
        rem   <= stretch;
        step  <= (stretch == top_in) ? '0 : stretch + CW'(1);
      end else if (busy) begin
        if (rem == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (tick) begin
          pre <= '0;
          rem <= rem - CW'(1);
        end else begin
          pre <= pre + DIV_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ecs_timer_chk.sv
module ecs_timer_chk #(
  parameter int DIV_W = 3,
  parameter int DEV_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [DIV_W-1:0] div_q,
  input logic [DEV_W-1:0] dev_q,
  input logic [DEV_W:0]   rem
);
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_fall_gives_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(en)) |-> done);
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start && !busy) |=> busy);
  assert_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && !done));
  assert_fields_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && en) |=> ($stable(div_q) && $stable(dev_q)));
  assert_busy_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && en && start && rem != '0) |=> (busy && rem <= $past(rem)));
  assert_rem_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem <= {1'b0, dev_q} + 1'b1));
endmodule

bind ecs_timer ecs_timer_chk #(.DIV_W(DIV_W), .DEV_W(DEV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .start(start), .busy(busy), .done(done),
  .div_q(div_q), .dev_q(dev_q), .rem(rem)
);

// File: tb/ecs_timer_tb.sv
module ecs_timer_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic en = 0;
  logic [2:0] div_sel = 0;
  logic [6:0] dev_sel = 0;
  logic start = 0;
  logic busy, done;

  int n_run = 0;
  int n_fail = 0;
  int model_step = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ecs_timer u_dut (.clk(clk), .rst_n(rst_n), .en(en), .div_sel(div_sel),
    .dev_sel(dev_sel), .start(start), .busy(busy), .done(done));

  function automatic int exp_len(int s, int d);
    return s * (d + 1) + 1;
  endfunction

  function automatic int next_stretch(int st, int v);
    return (st > v + 1) ? 0 : st;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one interval; optional disturbance at busy cycle 'poke' (0 = none)
  task automatic run_one(int d, int v, int poke, string req);
    int s, blen, cnt;
    s = next_stretch(model_step, v);
    model_step = (s == v + 1) ? 0 : s + 1;
    blen = exp_len(s, d);
    @(negedge clk);
    div_sel = 3'(d); dev_sel = 7'(v); start = 1;
    @(negedge clk);
    start = 0;
    cnt = 0;
    while (busy && cnt < 2000) begin
      cnt++;
      if (poke != 0 && cnt == poke) begin
        start = 1; div_sel = 3'(d ^ 5); dev_sel = 7'(v ^ 3);
      end else begin
        start = 0;
      end
      @(negedge clk);
    end
    start = 0;
    check(cnt == blen, req, cnt, blen);
    check(done == 1'b1, "R4 done after busy", int'(done), 1);
    @(negedge clk);
    check(done == 1'b0, "R4 done one cycle", int'(done), 0);
  endtask

  initial begin
    #20000000;
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0, "R1 reset", int'({busy, done}), 0);
    rst_n = 1;
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    check(busy == 0, "R8 start ignored when disabled", int'(busy), 0);
    en = 1;
    @(negedge clk);
    run_one(0, 2, 0, "R1 first stretch zero");
    run_one(0, 2, 0, "R5 sawtooth 1");
    run_one(1, 2, 0, "R3 div1 stretch2");
    run_one(2, 2, 0, "R5 stretch3 top");
    run_one(2, 2, 0, "R5 wrap to zero");
    run_one(3, 4, 0, "R5 stretch1");
    run_one(3, 4, 4, "R6 R7 poke during interval");
    run_one(3, 4, 0, "R6 sawtooth not advanced by poke");
    run_one(1, 0, 0, "R9 deviation lowered gives zero");
    run_one(1, 0, 0, "R5 stretch1 at v0");
    // abort by clearing enable
    run_one(0, 5, 0, "R5 before abort");
    @(negedge clk);
    div_sel = 3; dev_sel = 5; start = 1;
    @(negedge clk);
    start = 0;
    repeat (2) @(negedge clk);
    en = 0;
    @(negedge clk);
    check(busy == 0 && done == 0, "R8 abort", int'({busy, done}), 0);
    repeat (3) begin
      @(negedge clk);
      check(done == 0, "R8 no done after abort", int'(done), 0);
    end
    en = 1;
    model_step = 0;
    run_one(4, 5, 0, "R8 sawtooth reset");
    // long run to top of deviation 0x7F
    model_step = 0;
    en = 0; @(negedge clk); en = 1;
    for (int i = 0; i < 130; i++) run_one(7, 127, 0, "R5 R3 full range");
    // random mix
    for (int i = 0; i < 150; i++) begin
      int d, v, p;
      d = int'($urandom_range(0, 7));
      v = int'($urandom_range(0, 6));
      p = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 3)) : 0;
      run_one(d, v, p, "R3 random");
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule